// File: doc/BRIEF.md
# Zero-Substitution Line Coder with Violation Control

This block sits between a framer's serial data and a two-rail line interface for 1.544 and 2.048 Mbit/s links. On the transmit side it turns unipolar NRZ bits into alternate-mark-inversion pulses on a positive and a negative rail. It replaces long zero runs with substitution codes that contain deliberate bipolar violations: eight zeros in the T1 code, four zeros in the E1 code. On the receive side it turns rail pulses back into unipolar data. It removes valid substitution codes and reports every other violation on a flag output.

A configuration bit picks between unipolar data (coder active) and two-rail data (coder bypassed). The same bit allows test violations to be inserted and detected. A rising edge on the insert input forces one violation into the transmit stream. The block also provides an all-ones transmit pattern, a local loopback (transmit stream fed to the receive decoder) and a remote loopback (received rails sent back to the line). The loopbacks and the pattern decide where an inserted violation goes.

Top module: `lc_line_coder`

## Requirements
- R1: While reset is low, all four outputs are 0. After reset, the first mark each coded path emits is on the positive rail (`line_pos`=1, `line_neg`=0).
- R2: In unipolar mode, a 1 on `tx_pos` appears as a single pulse on exactly one rail 9 clock cycles later, and marks alternate polarity. The two line rails are never high together.
- R3: With `cfg_hdb3`=0, each eighth consecutive zero completes the code 0,0,0,V,B,0,V,B (oldest first) in place of the eight zeros. V repeats the polarity of the pulse before it and B takes the opposite polarity.
- R4: With `cfg_hdb3`=1, each fourth consecutive zero completes a substitution. It is 0,0,0,V when an odd number of data marks has entered since the previous substitution (or reset), and B,0,0,V otherwise. The zero and mark counts restart after every substitution.
- R5: In unipolar mode the decoder outputs each received bit on `rxo_pos` 9 cycles after it enters, with valid substitution codes of the selected line code restored to zeros and not flagged.
- R6: In unipolar mode, a received pulse that has the same polarity as the previous pulse and is not part of a valid substitution sets `rxo_neg` in the cycle its bit appears on `rxo_pos`. `rxo_neg` is only ever high together with `rxo_pos`.
- R7: With `cfg_unipolar`=0, `line_pos/line_neg` equal `tx_pos/tx_neg` one cycle earlier, and `rxo_pos/rxo_neg` equal `rx_pos/rx_neg` one cycle earlier, with no coding.
- R8: When insertion is allowed (unipolar mode, or the all-ones pattern active), a rising edge on `bpv_ins` makes exactly one later mark repeat the previous polarity. This holds in either I/O mode while the all-ones pattern runs.
- R9: A rising edge of `bpv_ins` in two-rail mode without the all-ones pattern, or while `cfg_rloop`=1, has no effect on the line, including after the loopback is released.
- R10: With `cfg_taos`=1 the line carries alternating marks every cycle. If `cfg_lloop` is also 1, an inserted violation goes only to the looped decoder and is flagged on `rxo_neg`, and the line stays free of violations.
- R11: With `cfg_lloop`=1 the decoder takes the transmit rails instead of `rx_pos/rx_neg`, while the line keeps transmitting them. Unipolar data returns on `rxo_pos` 18 cycles after entering.
- R12: With `cfg_rloop`=1, the line rails equal `rx_pos/rx_neg` one cycle earlier, overriding the all-ones pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_hdb3 | input | 1 | 1 = four-zero E1 code, 0 = eight-zero T1 code |
| cfg_unipolar | input | 1 | 1 = unipolar data with coder, insertion and detection |
| cfg_taos | input | 1 | Transmit all ones on the line |
| cfg_lloop | input | 1 | Local loopback: transmit rails into the decoder |
| cfg_rloop | input | 1 | Remote loopback: received rails back to the line |
| bpv_ins | input | 1 | Rising edge requests one inserted violation |
| tx_pos | input | 1 | Transmit data (unipolar) or positive rail (two-rail) |
| tx_neg | input | 1 | Transmit negative rail in two-rail mode |
| rx_pos | input | 1 | Received positive rail |
| rx_neg | input | 1 | Received negative rail |
| line_pos | output | 1 | Line positive rail |
| line_neg | output | 1 | Line negative rail |
| rxo_pos | output | 1 | Decoded data (unipolar) or positive rail (two-rail) |
| rxo_neg | output | 1 | Violation flag (unipolar) or negative rail (two-rail) |

## Verification
The bench builds the block with its default window of eight symbols, which is the only width that fits the eight-zero code. It runs a near-exhaustive sweep: blocks of one to three marks followed by zero runs of every length from 0 to 12, in both codes, through local loopback and through the receive pins. This covers both parity cases of the four-zero code, back-to-back and partial substitutions, and every run length around the thresholds. Expected rails come from an array-level model of the coding rules in the bench. Short targeted runs cover each routing of an inserted violation through the loopback and pattern combinations.

// File: rtl/lc_pkg.sv
// Shared constants and types for the zero-substitution line coder.
// Assumes the symbol window is at least as long as the longest substituted run.
package lc_pkg;
    localparam int B8_RUN = 8;                     // zeros replaced in the T1 code
    localparam int HD_RUN = 4;                     // zeros replaced in the E1 code
    localparam int WIN    = B8_RUN;                // look-ahead window depth
    localparam int ZW     = $clog2(B8_RUN + 1);    // zero-run counter width

    // Transmit symbol kinds before polarity is assigned
    typedef enum logic [1:0] {
        SYM_ZERO = 2'd0,   // no pulse
        SYM_MARK = 2'd1,   // pulse that alternates
        SYM_VIOL = 2'd2    // pulse repeating the previous polarity
    } sym_t;

    // One received symbol as held in the decoder window
    typedef struct packed {
        logic mark;   // a pulse was present
        logic pos;    // polarity of the pulse (1 = positive)
        logic viol;   // same polarity as the pulse before it
    } rx_ent_t;
endpackage

// File: rtl/lc_sub_encoder.sv
// Transmit substitution stage: delays unipolar bits through a window of
// WIN symbols and rewrites a completed zero run into the substitution code
// of the selected line code. Output is a symbol kind; polarity comes later.
// Assumes the code select is static while data flows.
module lc_sub_encoder
    import lc_pkg::*;
#(
    parameter int DEPTH = WIN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hdb3,
    input  logic din,
    output sym_t sym_out
);
    sym_t            buf_q [DEPTH];
    sym_t            nb    [DEPTH];
    logic [ZW-1:0]   zrun_q, zrun_n, lim;
    logic            odd_q, odd_n;

    // Next window content with substitution applied to the newest entries
    always_comb begin
        lim    = hdb3 ? ZW'(HD_RUN - 1) : ZW'(B8_RUN - 1);
        nb[0]  = din ? SYM_MARK : SYM_ZERO;
        for (int k = 1; k < DEPTH; k++) nb[k] = buf_q[k-1];
        zrun_n = zrun_q;
        odd_n  = odd_q;
        if (din) begin
            zrun_n = '0;
            odd_n  = ~odd_q;
        end else if (zrun_q == lim) begin
            zrun_n = '0;
            odd_n  = 1'b0;
            if (hdb3) begin
                nb[3] = odd_q ? SYM_ZERO : SYM_MARK;
                nb[0] = SYM_VIOL;
            end else begin
                nb[4] = SYM_VIOL;
                nb[3] = SYM_MARK;
                nb[1] = SYM_VIOL;
                nb[0] = SYM_MARK;
            end
        end else begin
            zrun_n = zrun_q + 1'b1;
        end
    end

    // Window shift and run/parity bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) buf_q[k] <= SYM_ZERO;
            zrun_q <= '0;
            odd_q  <= 1'b0;
        end else begin
            for (int k = 0; k < DEPTH; k++) buf_q[k] <= nb[k];
            zrun_q <= zrun_n;
            odd_q  <= odd_n;
        end
    end

    assign sym_out = buf_q[DEPTH-1];
endmodule

// File: rtl/lc_ami_stage.sv
// Polarity stage: turns symbol kinds into registered rail pulses.
// Marks alternate; violation symbols repeat the last polarity. A one-cycle
// inject request arms the stage so that the next mark repeats the last
// polarity instead, leaving the alternation state unchanged.
module lc_ami_stage
    import lc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  sym_t sym,
    input  logic inj,
    output logic pos,
    output logic neg
);
    logic last_q, armed_q;
    logic pulse, hold, pol;

    // Decide whether a pulse is sent and with which polarity
    always_comb begin
        pulse = (sym != SYM_ZERO);
        hold  = (sym == SYM_VIOL) || (armed_q && sym == SYM_MARK);
        pol   = hold ? last_q : ~last_q;
    end

    // Rail registers, polarity memory and the insertion arm
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos     <= 1'b0;
            neg     <= 1'b0;
            last_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            pos     <= pulse & pol;
            neg     <= pulse & ~pol;
            if (pulse) last_q <= pol;
            armed_q <= inj | (armed_q & (sym != SYM_MARK));
        end
    end
endmodule

// File: rtl/lc_sub_decoder.sv
// Receive decoder: classifies each rail pulse against the previous one,
// holds WIN symbols, clears valid substitution codes of the selected line
// code and emits data plus a violation flag. In two-rail mode the rails are
// registered straight through. Assumes the code select is static.
module lc_sub_decoder
    import lc_pkg::*;
#(
    parameter int DEPTH = WIN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hdb3,
    input  logic unipolar,
    input  logic in_pos,
    input  logic in_neg,
    output logic out_a,
    output logic out_b
);
    rx_ent_t buf_q [DEPTH];
    rx_ent_t nb    [DEPTH];
    rx_ent_t cur;
    logic    last_q, hit_b8, hit_hd;

    // Classify the incoming pulse and find completed substitution codes
    always_comb begin
        cur.mark = in_pos | in_neg;
        cur.pos  = in_pos;
        cur.viol = cur.mark & (in_pos == last_q);
        nb[0] = cur;
        for (int k = 1; k < DEPTH; k++) nb[k] = buf_q[k-1];
        hit_b8 = !nb[7].mark && !nb[6].mark && !nb[5].mark
              && nb[4].mark &&  nb[4].viol
              && nb[3].mark && !nb[3].viol
              && !nb[2].mark
              && nb[1].mark &&  nb[1].viol
              && nb[0].mark && !nb[0].viol;
        hit_hd = nb[0].mark && nb[0].viol && !nb[1].mark && !nb[2].mark
              && (!nb[3].mark || (!nb[3].viol && nb[3].pos == nb[0].pos));
        if (hdb3 && hit_hd)
            for (int k = 0; k < HD_RUN; k++) nb[k] = '0;
        if (!hdb3 && hit_b8)
            for (int k = 0; k < 5; k++) nb[k] = '0;
    end

    // Window shift, polarity memory and output selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) buf_q[k] <= '0;
            last_q <= 1'b0;
            out_a  <= 1'b0;
            out_b  <= 1'b0;
        end else begin
            for (int k = 0; k < DEPTH; k++) buf_q[k] <= nb[k];
            if (cur.mark) last_q <= in_pos;
            out_a <= unipolar ? buf_q[DEPTH-1].mark : in_pos;
            out_b <= unipolar ? buf_q[DEPTH-1].viol : in_neg;
        end
    end
endmodule

// File: rtl/lc_line_coder.sv
// Top of the line coder: transmit substitution and polarity, an all-ones
// pattern path, two-rail bypass, loopback routing, violation insertion
// steering and the receive decoder. Every output is a register or a mux
// of registers. Assumes configuration inputs change only between streams.
module lc_line_coder
    import lc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_hdb3,
    input  logic cfg_unipolar,
    input  logic cfg_taos,
    input  logic cfg_lloop,
    input  logic cfg_rloop,
    input  logic bpv_ins,
    input  logic tx_pos,
    input  logic tx_neg,
    input  logic rx_pos,
    input  logic rx_neg,
    output logic line_pos,
    output logic line_neg,
    output logic rxo_pos,
    output logic rxo_neg
);
    localparam int NPATH = 2;   // path 0: coded data, path 1: all ones

    sym_t enc_sym;
    sym_t sym_in [NPATH];
    logic [NPATH-1:0] inj, ami_pos, ami_neg;
    logic bpv_q, byp_pos, byp_neg, rxq_pos, rxq_neg;
    logic ins_edge, ins_ok, txs_pos, txs_neg, dec_pos, dec_neg;

    lc_sub_encoder #(.DEPTH(WIN)) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .hdb3    (cfg_hdb3),
        .din     (tx_pos),
        .sym_out (enc_sym)
    );

    // Steer an insertion request to the path whose output carries it
    always_comb begin
        ins_edge  = bpv_ins & ~bpv_q;
        ins_ok    = (cfg_unipolar | cfg_taos) & ~cfg_rloop;
        inj[0]    = ins_edge & ins_ok & (~cfg_taos | cfg_lloop);
        inj[1]    = ins_edge & ins_ok & cfg_taos & ~cfg_lloop;
        sym_in[0] = enc_sym;
        sym_in[1] = SYM_MARK;
    end

    for (genvar g = 0; g < NPATH; g++) begin : g_path
        lc_ami_stage u_ami (
            .clk   (clk),
            .rst_n (rst_n),
            .sym   (sym_in[g]),
            .inj   (inj[g]),
            .pos   (ami_pos[g]),
            .neg   (ami_neg[g])
        );
    end

    // Edge memory, two-rail bypass and remote-loop capture registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bpv_q   <= 1'b0;
            byp_pos <= 1'b0;
            byp_neg <= 1'b0;
            rxq_pos <= 1'b0;
            rxq_neg <= 1'b0;
        end else begin
            bpv_q   <= bpv_ins;
            byp_pos <= tx_pos;
            byp_neg <= tx_neg;
            rxq_pos <= rx_pos;
            rxq_neg <= rx_neg;
        end
    end

    // Line and decoder-input selection for the loopback and pattern modes
    always_comb begin
        txs_pos = cfg_unipolar ? ami_pos[0] : byp_pos;
        txs_neg = cfg_unipolar ? ami_neg[0] : byp_neg;
        if (cfg_rloop) begin
            line_pos = rxq_pos;
            line_neg = rxq_neg;
        end else if (cfg_taos) begin
            line_pos = ami_pos[1];
            line_neg = ami_neg[1];
        end else begin
            line_pos = txs_pos;
            line_neg = txs_neg;
        end
        dec_pos = cfg_lloop ? txs_pos : rx_pos;
        dec_neg = cfg_lloop ? txs_neg : rx_neg;
    end

    lc_sub_decoder #(.DEPTH(WIN)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .hdb3     (cfg_hdb3),
        .unipolar (cfg_unipolar),
        .in_pos   (dec_pos),
        .in_neg   (dec_neg),
        .out_a    (rxo_pos),
        .out_b    (rxo_neg)
    );
endmodule

// File: rtl/lc_line_coder_chk.sv
// Port-level checker for the line coder, bound into every instance.
module lc_line_coder_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_unipolar,
    input logic cfg_taos,
    input logic cfg_lloop,
    input logic cfg_rloop,
    input logic tx_pos,
    input logic tx_neg,
    input logic rx_pos,
    input logic rx_neg,
    input logic line_pos,
    input logic line_neg,
    input logic rxo_pos,
    input logic rxo_neg
);
    logic [1:0] age;

    // Count clock edges since reset release, saturating at three
    always_ff @(posedge clk) begin
        if (!rst_n) age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R2
    rail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_unipolar && !cfg_rloop) |-> !(line_pos && line_neg));

    // R6
    flag_with_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && cfg_unipolar && $past(cfg_unipolar) && rxo_neg) |-> rxo_pos);

    // R7
    bypass_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && !cfg_unipolar && !cfg_taos && !cfg_rloop)
        |-> (line_pos == $past(tx_pos) && line_neg == $past(tx_neg)));

    // R10
    taos_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && cfg_taos && !cfg_rloop && $past(cfg_taos))
        |-> ($countones({line_pos, line_neg}) == 1));

    // R10
    taos_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && cfg_taos && cfg_lloop && !cfg_rloop
         && $past(cfg_taos && cfg_lloop && !cfg_rloop) && line_pos)
        |-> $past(line_neg));

    // R12
    rloop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && cfg_rloop)
        |-> (line_pos == $past(rx_pos) && line_neg == $past(rx_neg)));
endmodule

bind lc_line_coder lc_line_coder_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_unipolar (cfg_unipolar),
    .cfg_taos     (cfg_taos),
    .cfg_lloop    (cfg_lloop),
    .cfg_rloop    (cfg_rloop),
    .tx_pos       (tx_pos),
    .tx_neg       (tx_neg),
    .rx_pos       (rx_pos),
    .rx_neg       (rx_neg),
    .line_pos     (line_pos),
    .line_neg     (line_neg),
    .rxo_pos      (rxo_pos),
    .rxo_neg      (rxo_neg)
);

// File: tb/sim_lc_line_coder.sv
// Self-checking bench: run-length sweeps in both codes plus targeted
// insertion, loopback and bypass runs.
module sim_lc_line_coder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_hdb3 = 0, cfg_unipolar = 0, cfg_taos = 0, cfg_lloop = 0, cfg_rloop = 0;
    logic bpv_ins = 0, tx_pos = 0, tx_neg = 0, rx_pos = 0, rx_neg = 0;
    logic line_pos, line_neg, rxo_pos, rxo_neg;

    int checks = 0;
    int errors = 0;
    bit stim [512];
    bit rp [512];
    bit rn [512];
    int symv [512];
    int nstim = 0;
    int vlast, vcount, fcount, firstpol;
    bit done = 0;

    always #4 clk = ~clk;

    lc_line_coder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_hdb3(cfg_hdb3), .cfg_unipolar(cfg_unipolar),
        .cfg_taos(cfg_taos), .cfg_lloop(cfg_lloop), .cfg_rloop(cfg_rloop),
        .bpv_ins(bpv_ins), .tx_pos(tx_pos), .tx_neg(tx_neg), .rx_pos(rx_pos),
        .rx_neg(rx_neg), .line_pos(line_pos), .line_neg(line_neg),
        .rxo_pos(rxo_pos), .rxo_neg(rxo_neg)
    );

    task automatic chk(input string tag, input int act, input int exp, input int cyc);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    // Reset with a configuration; returns at the negedge releasing reset
    task automatic start(input bit h, input bit u, input bit t, input bit ll, input bit rl);
        rst_n = 0;
        cfg_hdb3 = h; cfg_unipolar = u; cfg_taos = t; cfg_lloop = ll; cfg_rloop = rl;
        bpv_ins = 0; tx_pos = 0; tx_neg = 0; rx_pos = 0; rx_neg = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {line_pos, line_neg, rxo_pos, rxo_neg}, 0, 0);
        rst_n = 1;
    endtask

    // Stimulus: 1..3 marks then 0..12 zeros, every combination, then padding
    task automatic build_sweep();
        nstim = 0;
        for (int z = 0; z <= 12; z++)
            for (int k = 1; k <= 3; k++) begin
                for (int i = 0; i < k; i++) begin stim[nstim] = 1; nstim++; end
                for (int i = 0; i < z; i++) begin stim[nstim] = 0; nstim++; end
            end
        for (int i = 0; i < 24; i++) begin stim[nstim] = 0; nstim++; end
    endtask

    // Array model of the substitution and polarity rules (R3, R4, R2)
    task automatic model(input bit h);
        int zr, lim, last, pol;
        bit odd;
        zr = 0; odd = 0; last = 0;
        lim = h ? 4 : 8;
        for (int i = 0; i < nstim; i++) begin
            if (stim[i]) begin
                symv[i] = 1; zr = 0; odd = ~odd;
            end else begin
                symv[i] = 0; zr++;
                if (zr == lim) begin
                    if (h) begin
                        symv[i-3] = odd ? 0 : 1;
                        symv[i] = 2;
                    end else begin
                        symv[i-4] = 2; symv[i-3] = 1; symv[i-1] = 2; symv[i] = 1;
                    end
                    zr = 0; odd = 0;
                end
            end
        end
        for (int i = 0; i < nstim; i++) begin
            if (symv[i] == 0) begin rp[i] = 0; rn[i] = 0; end
            else begin
                pol = (symv[i] == 2) ? last : 1 - last;
                last = pol;
                rp[i] = (pol == 1); rn[i] = (pol == 0);
            end
        end
    endtask

    // Sweep through the encoder with local loopback into the decoder
    task automatic enc_sweep(input bit h);
        int ep, en;
        model(h);
        start(h, 1, 0, 1, 0);
        for (int j = 0; j < nstim; j++) begin
            if (j > 0) @(negedge clk);
            ep = (j >= 9) ? rp[j-9] : 0;
            en = (j >= 9) ? rn[j-9] : 0;
            chk(h ? "R4 line code" : "R3 line code", {line_pos, line_neg}, {ep[0], en[0]}, j);
            chk("R11 looped data", rxo_pos, (j >= 18) ? stim[j-18] : 0, j);
            chk("R5 no flag", rxo_neg, 0, j);
            tx_pos = stim[j];
        end
    endtask

    // Model rails driven on the receive pins
    task automatic dec_sweep(input bit h);
        model(h);
        start(h, 1, 0, 0, 0);
        for (int j = 0; j < nstim; j++) begin
            if (j > 0) @(negedge clk);
            chk("R5 decoded data", rxo_pos, (j >= 9) ? stim[j-9] : 0, j);
            chk("R5 no flag", rxo_neg, 0, j);
            rx_pos = rp[j]; rx_neg = rn[j];
        end
    endtask

    // Track line violations and flags over n cycles of constant data
    task automatic run_count(input int n, input int bpv_at, input bit data);
        vlast = -1; vcount = 0; fcount = 0; firstpol = -1;
        for (int j = 0; j < n; j++) begin
            if (j > 0) @(negedge clk);
            if (line_pos | line_neg) begin
                if (firstpol < 0) firstpol = line_pos;
                if (vlast == int'(line_pos)) vcount++;
                vlast = line_pos;
            end
            fcount += rxo_neg;
            tx_pos = data;
            bpv_ins = (j >= bpv_at && j < bpv_at + 2);
        end
    endtask

    initial begin
        build_sweep();
        enc_sweep(0);
        enc_sweep(1);
        dec_sweep(0);
        dec_sweep(1);

        // R6: stray violation at pulse 20 of an alternating stream
        begin
            int pol;
            pol = 1;
            start(0, 1, 0, 0, 0);
            for (int j = 0; j < 50; j++) begin
                if (j > 0) @(negedge clk);
                chk("R6 flag", rxo_neg, (j - 9 == 20) ? 1 : 0, j);
                chk("R6 data", rxo_pos, (j >= 9 && j < 49) ? 1 : 0, j);
                if (j < 40) begin
                    rx_pos = (pol == 1); rx_neg = (pol == 0);
                    if (j != 19) pol = 1 - pol;
                end else begin
                    rx_pos = 0; rx_neg = 0;
                end
            end
        end

        // R7 / R9: two-rail bypass with insert pulses that must be ignored
        start(0, 0, 0, 0, 0);
        for (int j = 0; j < 60; j++) begin
            if (j > 0) @(negedge clk);
            chk("R7 R9 line bypass", {line_pos, line_neg},
                (j >= 1) ? {((j-1) % 3 == 0), ((j-1) % 5 == 2)} : 0, j);
            chk("R7 rx bypass", {rxo_pos, rxo_neg},
                (j >= 1) ? {((j-1) % 4 == 0), ((j-1) % 7 == 3)} : 0, j);
            tx_pos = (j % 3 == 0); tx_neg = (j % 5 == 2);
            rx_pos = (j % 4 == 0); rx_neg = (j % 7 == 3);
            bpv_ins = (j % 10 < 3);
        end

        // R8: insertion in unipolar mode, first mark positive (R1)
        start(0, 1, 0, 0, 0);
        run_count(60, 25, 1);
        chk("R8 unipolar insert count", vcount, 1, 0);
        chk("R1 first mark positive", firstpol, 1, 0);

        // R8: insertion in two-rail mode with the all-ones pattern
        start(0, 0, 1, 0, 0);
        run_count(60, 25, 0);
        chk("R8 pattern insert count", vcount, 1, 0);

        // R10: pattern with local loopback, violation only on the loop
        start(0, 1, 1, 1, 0);
        run_count(80, 25, 1);
        chk("R10 line clean", vcount, 0, 0);
        chk("R10 loop flag count", fcount, 1, 0);

        // R12 then R9: remote loopback overrides pattern and blocks insertion
        start(0, 1, 1, 0, 1);
        for (int j = 0; j < 30; j++) begin
            if (j > 0) @(negedge clk);
            chk("R12 remote loop", {line_pos, line_neg},
                (j >= 1) ? {((j-1) % 3 == 1), ((j-1) % 4 == 2)} : 0, j);
            rx_pos = (j % 3 == 1); rx_neg = (j % 4 == 2);
            bpv_ins = (j >= 10 && j < 12);
        end
        @(negedge clk);
        cfg_rloop = 0; rx_pos = 0; rx_neg = 0;
        run_count(40, 1000, 1);
        chk("R9 no insert after remote loop", vcount, 0, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0 expected 1 (run completion)");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule